// File: doc/BRIEF.md
# Fixed-Cycle Two-Way Traffic Light Sequencer

This block drives the lamps of a crossing where a north-south street meets an east-west street. It takes no requests and no sensor inputs. A small binary step counter advances once per clock through a ten-step schedule and then starts again. In each direction the lamps show green for four steps, yellow for one step and red for five. While one direction shows green or yellow, the other is held at red.

The lamp outputs are decoded combinationally from the registered step count. The design uses only flip-flops and gates; there is no table or memory lookup. The green and yellow lengths are parameters, and the period is derived from them. A synchronous reset restarts the schedule at step 0. If the counter ever holds one of the six unused codes, all lamps show red and the counter returns to step 0 on the next edge.

Top module: `signal_sequencer`

## Requirements
- R1: With `rst` high at a rising edge, the step count becomes 0 at that edge. After that edge the outputs show east-west green and north-south red.
- R2: With `rst` low, each rising edge advances the step count by one. Step 9 is followed by step 0, so the schedule repeats every 10 clocks.
- R3: East-west lamps: green in steps 0 to 3, yellow in step 4, red in steps 5 to 9.
- R4: North-south lamps: red in steps 0 to 4, green in steps 5 to 8, yellow in step 9.
- R5: Over any three full periods that start at step 0, each direction shows green for 12 cycles, yellow for 3 cycles and red for 15 cycles.
- R6: In every state, including the unused codes, exactly one of the three lamps of each direction is on.
- R7: Whenever either direction shows green or yellow, the other direction shows red.
- R8: For the unused count codes 10 to 15, both directions show red while the code is held. The next rising edge with `rst` low loads step 0.
- R9: A reset applied in the middle of the schedule restarts it at step 0, whatever the current step is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the step count advances on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ew_stop | output | 1 | East-west red lamp |
| ew_warn | output | 1 | East-west yellow lamp |
| ew_go | output | 1 | East-west green lamp |
| ns_stop | output | 1 | North-south red lamp |
| ns_warn | output | 1 | North-south yellow lamp |
| ns_go | output | 1 | North-south green lamp |

## Verification
The bench runs the schedule in three ways:

- **Long free run after reset.** Thirty clocks are run from step 0 with no reset. Counting the cycles each lamp is lit checks the 4/1/5 split. A schedule that is off by one step, or that wraps early or late, changes these totals.
- **Random resets.** A long run inserts resets at random times from a fixed seed. Each cycle's lamps are compared with a bench model of the step count. This separates a correct restart from one that depends on the current step.
- **Directed loads of unused codes.** Each of the six unused codes is forced into the counter. The bench checks that all lamps go red and that the next edge brings the schedule back to step 0, which shows whether the recovery path exists.

// File: rtl/sigseq_pkg.sv
package sigseq_pkg;

   typedef struct packed {
      logic stop;
      logic warn;
      logic go;
   } lamp_t;

   function automatic int unsigned period_of(input int unsigned go_n,
                                             input int unsigned warn_n);
      return 2 * (go_n + warn_n);
   endfunction

   function automatic int unsigned count_width(input int unsigned period);
      return (period <= 2) ? 1 : $clog2(period);
   endfunction

endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
   parameter int unsigned PERIOD  = 10,
   parameter int unsigned STATE_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   output logic [STATE_W-1:0] count_q
);
   localparam logic [STATE_W-1:0] LAST = STATE_W'(PERIOD - 1);

   if (PERIOD < 2) begin : g_bad_period
      $error("seq_counter: PERIOD must be at least 2");
   end
   if ((1 << STATE_W) < PERIOD) begin : g_bad_width
      $error("seq_counter: STATE_W too narrow for PERIOD");
   end

   logic [STATE_W-1:0] count_d;

   always_comb begin
      if (count_q >= LAST) count_d = '0;
      else                 count_d = count_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) count_q <= '0;
      else     count_q <= count_d;
   end

   // R2
   step_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(count_q) < LAST)) |-> (count_q == $past(count_q) + 1'b1));

   // R2
   wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(count_q) == LAST)) |-> (count_q == '0));

   // R8
   recover_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(count_q) > LAST)) |-> (count_q == '0));

endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
   import sigseq_pkg::*;
#(
   parameter int unsigned GO_CYCLES   = 4,
   parameter int unsigned WARN_CYCLES = 1,
   parameter int unsigned STATE_W     = 4,
   parameter int unsigned BASE        = 0
) (
   input  logic [STATE_W-1:0] count,
   output lamp_t              lamp
);
   localparam int unsigned HALF = GO_CYCLES + WARN_CYCLES;

   if (GO_CYCLES < 1) begin : g_bad_go
      $error("lamp_decode: GO_CYCLES must be at least 1");
   end
   if (WARN_CYCLES < 1) begin : g_bad_warn
      $error("lamp_decode: WARN_CYCLES must be at least 1");
   end

   int unsigned cnt_u;
   int unsigned rel;

   always_comb begin
      cnt_u = 32'(count);
      rel   = cnt_u - BASE;
      lamp  = '0;
      if ((cnt_u >= BASE) && (cnt_u < BASE + HALF)) begin
         if (rel < GO_CYCLES) lamp.go   = 1'b1;
         else                 lamp.warn = 1'b1;
      end else begin
         lamp.stop = 1'b1;
      end
   end

   // R6
   onehot_chk: assert final ($countones(lamp) == 1);

endmodule

// File: rtl/signal_sequencer.sv
module signal_sequencer
   import sigseq_pkg::*;
#(
   parameter int unsigned GO_CYCLES   = 4,
   parameter int unsigned WARN_CYCLES = 1
) (
   input  logic clk,
   input  logic rst,
   output logic ew_stop,
   output logic ew_warn,
   output logic ew_go,
   output logic ns_stop,
   output logic ns_warn,
   output logic ns_go
);
   localparam int unsigned HALF    = GO_CYCLES + WARN_CYCLES;
   localparam int unsigned PERIOD  = period_of(GO_CYCLES, WARN_CYCLES);
   localparam int unsigned STATE_W = count_width(PERIOD);
   localparam int unsigned N_DIR   = 2;

   logic [STATE_W-1:0] count_q;
   lamp_t              dir_lamp [N_DIR];

   seq_counter #(
      .PERIOD  (PERIOD),
      .STATE_W (STATE_W)
   ) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .count_q (count_q)
   );

   // direction 0 is east-west (first half), direction 1 is north-south
   for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      lamp_decode #(
         .GO_CYCLES   (GO_CYCLES),
         .WARN_CYCLES (WARN_CYCLES),
         .STATE_W     (STATE_W),
         .BASE        (d * HALF)
      ) u_dec (
         .count (count_q),
         .lamp  (dir_lamp[d])
      );
   end

   assign ew_stop = dir_lamp[0].stop;
   assign ew_warn = dir_lamp[0].warn;
   assign ew_go   = dir_lamp[0].go;
   assign ns_stop = dir_lamp[1].stop;
   assign ns_warn = dir_lamp[1].warn;
   assign ns_go   = dir_lamp[1].go;

   // R7
   ew_excl_chk: assert property (@(posedge clk) disable iff (rst)
      (ew_go || ew_warn) |-> (ns_stop && !ns_go && !ns_warn));

   // R7
   ns_excl_chk: assert property (@(posedge clk) disable iff (rst)
      (ns_go || ns_warn) |-> (ew_stop && !ew_go && !ew_warn));

   // R6
   dir_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones({ew_stop, ew_warn, ew_go}) == 1) && ($countones({ns_stop, ns_warn, ns_go}) == 1));

   // R8
   unused_red_chk: assert property (@(posedge clk) disable iff (rst)
      (32'(count_q) >= PERIOD) |-> (ew_stop && ns_stop));

   // R4
   ns_warn_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(ns_warn) && !$past(rst)) |-> (ew_go && ns_stop));

endmodule

// File: tb/test_signal_sequencer.sv
`timescale 1ns/1ps
module test_signal_sequencer;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ew_stop, ew_warn, ew_go, ns_stop, ns_warn, ns_go;

   int total = 0;
   int bad   = 0;
   int model = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   signal_sequencer i_signal_sequencer (
      .clk     (clk),
      .rst     (rst),
      .ew_stop (ew_stop),
      .ew_warn (ew_warn),
      .ew_go   (ew_go),
      .ns_stop (ns_stop),
      .ns_warn (ns_warn),
      .ns_go   (ns_go)
   );

   // encoding {stop, warn, go}
   function automatic logic [2:0] exp_ew(input int c);
      if (c < 4)       return 3'b001;
      else if (c == 4) return 3'b010;
      else             return 3'b100;
   endfunction

   function automatic logic [2:0] exp_ns(input int c);
      if (c < 5)       return 3'b100;
      else if (c < 9)  return 3'b001;
      else if (c == 9) return 3'b010;
      else             return 3'b100;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (step %0d)", req, act, exp, model);
      end
   endtask

   task automatic check_state();
      logic [2:0] ew, ns;
      ew = {ew_stop, ew_warn, ew_go};
      ns = {ns_stop, ns_warn, ns_go};
      check("R2/R3 east-west lamps", ew, exp_ew(model));
      check("R2/R4 north-south lamps", ns, exp_ns(model));
      check("R6 one lamp per direction", ($countones(ew) == 1) && ($countones(ns) == 1), 1);
      check("R7 cross exclusion", (ew[2] || ns[2]), 1);
   endtask

   task automatic step(input bit r);
      rst = r;
      @(posedge clk);
      if (r)              model = 0;
      else if (model >= 9) model = 0;
      else                model = model + 1;
      @(negedge clk);
      check_state();
   endtask

   initial begin
      int go_e, wa_e, st_e, go_n, wa_n, st_n;
      void'($urandom(32'd2718));
      @(negedge clk);
      step(1'b1);
      // R1
      check("R1 reset ew green", {ew_stop, ew_warn, ew_go}, 3'b001);
      check("R1 reset ns red", {ns_stop, ns_warn, ns_go}, 3'b100);

      // R5 three full periods from step 0
      go_e = 0; wa_e = 0; st_e = 0; go_n = 0; wa_n = 0; st_n = 0;
      for (int i = 0; i < 30; i++) begin
         go_e += int'(ew_go); wa_e += int'(ew_warn); st_e += int'(ew_stop);
         go_n += int'(ns_go); wa_n += int'(ns_warn); st_n += int'(ns_stop);
         step(1'b0);
      end
      check("R5 ew green cycles", go_e, 12);
      check("R5 ew yellow cycles", wa_e, 3);
      check("R5 ew red cycles", st_e, 15);
      check("R5 ns green cycles", go_n, 12);
      check("R5 ns yellow cycles", wa_n, 3);
      check("R5 ns red cycles", st_n, 15);
      check("R5 back at step 0", {ew_go, ns_stop}, 2'b11);

      // R9 reset in the middle of each step
      for (int k = 1; k < 10; k++) begin
         for (int j = 0; j < k; j++) step(1'b0);
         step(1'b1);
         check("R9 mid-schedule restart", {ew_stop, ew_warn, ew_go, ns_stop, ns_warn, ns_go}, 6'b001100);
      end

      // R8 unused codes
      for (int code = 10; code < 16; code++) begin
         step(1'b1);
         force i_signal_sequencer.u_cnt.count_q = 4'(code);
         release i_signal_sequencer.u_cnt.count_q;
         #1;
         model = code;
         check("R8 unused code all red", {ew_stop, ew_warn, ew_go, ns_stop, ns_warn, ns_go}, 6'b100100);
         step(1'b0);
         check("R8 recovery to step 0", {ew_go, ns_stop}, 2'b11);
      end

      // random resets mixed with free running
      step(1'b1);
      for (int i = 0; i < 400; i++) begin
         step($urandom_range(0, 29) == 0);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule